// File: doc/BRIEF.md
# Bidirectional Common Row Scan Shifter

This block walks a single start-of-frame token across the common (row) outputs of a 120-output display driver that is configured for common-only or mixed common/segment operation. The token enters on one of two cascade pins. Each row-step strobe moves it one row along, so the row being driven is the one whose select line is high. When the token reaches the far end of the configured field, the block raises the other cascade pin for one step period, so that the next chip in the chain can take over.

A 3-bit configuration picks how many outputs form the common field: none, or 32 to 120. The direction input sets which end of the 120-wide output array the field is anchored to, which cascade pin receives the token and which pin passes it on. In mixed mode the rest of the array is left to segment logic, which is outside this block. A display-off input clears all shifter stages. A blank control forces every common select line inactive while the scan keeps running. All inputs are sampled on the rising edge of `clk`. The row step is a one-cycle strobe, synchronous to `clk`, that stands in for the external line latch pulse. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level or strobe.

Top module: `cmscan_top`

## Requirements
- R1: After reset, all 120 select lines and both token outputs are low.
- R2: The field length is decoded from `com_cfg`: 001=32, 010=48, 011=64, 100=80, 101=96, 110=112, 111=120. Code 000 means no common field: every select line and both token outputs stay low and no token is held.
- R3: On a rising edge where `row_step` is high, each stage passes its token to the next stage and stage 0 loads the entry pin. On an edge where `row_step` is low, no stage gains a token.
- R4: With `scan_dir`=1, the token enters on `tok_a_in`, and stage k drives `com_sel[k]`, so the scan runs from output 0 upward. With `scan_dir`=0, the token enters on `tok_b_in`, and stage k drives `com_sel[119-k]`, so the scan runs from output 119 downward. The entry pin of the other direction is ignored.
- R5: While the last stage of the configured length holds a token, the exit pin is high: `tok_b_out` when `scan_dir`=1, `tok_a_out` when `scan_dir`=0. The other token output stays low, and both are low otherwise.
- R6: A token stepped out of the last stage is discarded. Select lines outside the configured field are never high.
- R7: On any edge where `disp_off` is high, all stages are cleared and a row step has no effect.
- R8: While `blank` is high, every select line is low, but stepping and the token outputs continue. When `blank` falls, the select line of the current position appears again.
- R9: A token that arrives while an earlier token is still in the field loads into stage 0. The earlier token keeps moving, so both positions are selected.
- R10: When `com_cfg` shrinks the field, tokens in stages beyond the new length are cleared at the next edge. Tokens inside the new length are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_step | input | 1 | One-cycle row advance strobe |
| scan_dir | input | 1 | 1: scan from output 0 up; 0: scan from output 119 down |
| disp_off | input | 1 | Clears all stages while high |
| blank | input | 1 | Forces all select lines low while high |
| com_cfg | input | 3 | Common field length code |
| tok_a_in | input | 1 | Cascade token input, A end |
| tok_b_in | input | 1 | Cascade token input, B end |
| tok_a_out | output | 1 | Cascade token output, A end |
| tok_b_out | output | 1 | Cascade token output, B end |
| com_sel | output | 120 | Common row select lines |

## Verification
A stage that holds a stray or lost token shows up on the select lines in the same cycle it appears. It also shows up as a wrong or missing token on the exit pin up to one field length of row steps later. The bench therefore compares the whole select vector and both token pins after every clock edge, not only at row boundaries. A length or direction mismapping makes the first select line appear at the wrong end at the first step after a token enters. It also moves the exit pulse to the wrong step count, which each length code checks exactly.

// File: rtl/cmscan_pkg.sv
package cmscan_pkg;
  localparam int unsigned CFG_W = 3;

  // Field length per configuration code; code 0 leaves no common field.
  function automatic int unsigned com_len(input logic [CFG_W-1:0] code,
                                          input int unsigned      n_out);
    int unsigned l;
    if (code == '0)
      l = 0;
    else if (code == '1)
      l = n_out;
    else
      l = 16 + 16 * int'(code);
    if (l > n_out) l = n_out;
    return l;
  endfunction
endpackage

// File: rtl/cmscan_len_dec.sv
module cmscan_len_dec
  import cmscan_pkg::*;
#(
  parameter int unsigned NUM_OUT = 120
) (
  input  logic [CFG_W-1:0]   cfg,
  output logic [NUM_OUT-1:0] keep_mask,
  output logic [NUM_OUT-1:0] last_pos
);
  localparam int unsigned LW = $clog2(NUM_OUT + 1);

  logic [LW-1:0] len;

  always_comb len = LW'(com_len(cfg, NUM_OUT));

  for (genvar k = 0; k < int'(NUM_OUT); k++) begin : g_stage
    assign keep_mask[k] = (LW'(k) < len);
    assign last_pos[k]  = (LW'(k + 1) == len);
  end
endmodule

// File: rtl/cmscan_chain.sv
module cmscan_chain #(
  parameter int unsigned NUM_OUT = 120
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               clear,
  input  logic               tok_in,
  input  logic [NUM_OUT-1:0] keep_mask,
  output logic [NUM_OUT-1:0] stages
);
  logic [NUM_OUT-1:0] nxt;

  always_comb begin
    if (clear)
      nxt = '0;
    else if (step)
      nxt = {stages[NUM_OUT-2:0], tok_in} & keep_mask;
    else
      nxt = stages & keep_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stages <= '0;
    else        stages <= nxt;
  end

  AST_DISPOFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (stages == '0)); // R7
  AST_STEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && keep_mask[0]) |=> (stages[0] == $past(tok_in))); // R3
  AST_IDLE_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (!step) |=> ((stages & ~$past(stages)) == '0)); // R3
endmodule

// File: rtl/cmscan_outmap.sv
module cmscan_outmap #(
  parameter int unsigned NUM_OUT = 120
) (
  input  logic [NUM_OUT-1:0] stages,
  input  logic [NUM_OUT-1:0] keep_mask,
  input  logic [NUM_OUT-1:0] last_pos,
  input  logic               dir_up,
  input  logic               blank,
  output logic [NUM_OUT-1:0] sel,
  output logic               exit_a,
  output logic               exit_b
);
  logic [NUM_OUT-1:0] live, fwd, rev;
  logic               at_end;

  assign live = stages & keep_mask;

  for (genvar k = 0; k < int'(NUM_OUT); k++) begin : g_map
    assign fwd[k]             = live[k];
    assign rev[NUM_OUT-1-k]   = live[k];
  end

  always_comb begin
    if (blank)       sel = '0;
    else if (dir_up) sel = fwd;
    else             sel = rev;
  end

  assign at_end = |(live & last_pos);
  assign exit_b = at_end & dir_up;
  assign exit_a = at_end & ~dir_up;
endmodule

// File: rtl/cmscan_top.sv
module cmscan_top
  import cmscan_pkg::*;
#(
  parameter int unsigned NUM_OUT = 120
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               row_step,
  input  logic               scan_dir,
  input  logic               disp_off,
  input  logic               blank,
  input  logic [CFG_W-1:0]   com_cfg,
  input  logic               tok_a_in,
  input  logic               tok_b_in,
  output logic               tok_a_out,
  output logic               tok_b_out,
  output logic [NUM_OUT-1:0] com_sel
);
  logic [NUM_OUT-1:0] keep_mask, last_pos, stages;
  logic               entry_tok;

  assign entry_tok = scan_dir ? tok_a_in : tok_b_in;

  cmscan_len_dec #(.NUM_OUT(NUM_OUT)) u_len (
    .cfg       (com_cfg),
    .keep_mask (keep_mask),
    .last_pos  (last_pos)
  );

  cmscan_chain #(.NUM_OUT(NUM_OUT)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (row_step),
    .clear     (disp_off),
    .tok_in    (entry_tok),
    .keep_mask (keep_mask),
    .stages    (stages)
  );

  cmscan_outmap #(.NUM_OUT(NUM_OUT)) u_map (
    .stages    (stages),
    .keep_mask (keep_mask),
    .last_pos  (last_pos),
    .dir_up    (scan_dir),
    .blank     (blank),
    .sel       (com_sel),
    .exit_a    (tok_a_out),
    .exit_b    (tok_b_out)
  );

  AST_ONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tok_a_out, tok_b_out})); // R5
  AST_NO_FIELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (com_cfg == '0) |-> (com_sel == '0 && !tok_a_out && !tok_b_out)); // R2
  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (com_sel == '0)); // R8
  AST_SHORT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_dir && com_cfg == 3'd1) |-> (com_sel[NUM_OUT-1:32] == '0)); // R6
endmodule

// File: tb/tb_cmscan_top.sv
module tb_cmscan_top;
  localparam int N = 120;

  logic         clk = 0, rst_n = 0;
  logic         row_step = 0, scan_dir = 1, disp_off = 0, blank = 0;
  logic [2:0]   com_cfg = 3'd1;
  logic         tok_a_in = 0, tok_b_in = 0;
  logic         tok_a_out, tok_b_out;
  logic [N-1:0] com_sel;

  cmscan_top #(.NUM_OUT(N)) dut (.*);

  always #2 clk = ~clk; // 250 MHz

  typedef struct {
    logic [N-1:0] sel;
    logic         a;
    logic         b;
    string        tag;
  } exp_t;

  exp_t         q[$];
  logic [N-1:0] st = '0;
  int           vectors = 0, miscompares = 0, cycles = 0;
  bit           done = 0;

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 32;
      3'd2: return 48;
      3'd3: return 64;
      3'd4: return 80;
      3'd5: return 96;
      3'd6: return 112;
      default: return 120;
    endcase
  endfunction

  // Driver: set inputs, advance the reference, queue what must appear after the edge.
  task automatic apply(input logic stp, input logic ta, input logic tb,
                       input logic dir, input logic off, input logic blk,
                       input logic [2:0] cfg, input string tag);
    exp_t e;
    int   l;
    logic tin;
    @(negedge clk);
    row_step = stp; tok_a_in = ta; tok_b_in = tb; scan_dir = dir;
    disp_off = off; blank = blk; com_cfg = cfg;
    l   = len_of(cfg);
    tin = dir ? ta : tb;
    if (off || l == 0) st = '0;
    else begin
      if (stp) st = {st[N-2:0], tin};
      for (int k = 0; k < N; k++) if (k >= l) st[k] = 1'b0;
    end
    e.sel = '0;
    if (!blk)
      for (int k = 0; k < l; k++)
        if (dir) e.sel[k] = st[k]; else e.sel[N-1-k] = st[k];
    e.b   = (l > 0) && st[l-1] && dir;
    e.a   = (l > 0) && st[l-1] && !dir;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare just after each edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (com_sel !== e.sel || tok_a_out !== e.a || tok_b_out !== e.b) begin
        miscompares++;
        $display("FAIL %s: sel=%h a=%b b=%b expected sel=%h a=%b b=%b",
                 e.tag, com_sel, tok_a_out, tok_b_out, e.sel, e.a, e.b);
      end
    end
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        miscompares++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    apply(0, 0, 0, 1, 0, 0, 3'd1, "R1");
    // R4/R5/R6: upward scan, 32 rows, exit on B then discard
    apply(1, 1, 0, 1, 0, 0, 3'd1, "R4");
    for (int i = 0; i < 34; i++) apply(1, 0, 0, 1, 0, 0, 3'd1, "R5_R6");
    // R3: hold without steps
    apply(1, 1, 0, 1, 0, 0, 3'd1, "R3");
    for (int i = 0; i < 4; i++) apply(1, 0, 0, 1, 0, 0, 3'd1, "R3");
    for (int i = 0; i < 4; i++) apply(0, 1, 1, 1, 0, 0, 3'd1, "R3");
    apply(1, 0, 0, 1, 1, 0, 3'd1, "R7");
    // R4: B entry ignored in upward direction
    apply(1, 0, 1, 1, 0, 0, 3'd1, "R4");
    apply(1, 0, 0, 1, 0, 0, 3'd1, "R4");
    // R4/R5: downward scan over full 120
    apply(1, 0, 1, 0, 0, 0, 3'd7, "R4");
    for (int i = 0; i < 121; i++) apply(1, 0, 0, 0, 0, 0, 3'd7, "R5_R6");
    apply(1, 1, 0, 0, 0, 0, 3'd7, "R4");
    apply(1, 0, 0, 0, 0, 0, 3'd7, "R4");
    // R8: blank mid-scan, 64 rows
    apply(1, 1, 0, 1, 0, 0, 3'd3, "R8");
    for (int i = 0; i < 5; i++)  apply(1, 0, 0, 1, 0, 0, 3'd3, "R8");
    for (int i = 0; i < 60; i++) apply(1, 0, 0, 1, 0, 1, 3'd3, "R8");
    for (int i = 0; i < 3; i++)  apply(1, 0, 0, 1, 0, 0, 3'd3, "R8");
    // R7: display off with steps and token present
    apply(1, 1, 0, 1, 0, 0, 3'd3, "R7");
    for (int i = 0; i < 6; i++) apply(1, 0, 0, 1, 0, 0, 3'd3, "R7");
    for (int i = 0; i < 3; i++) apply(1, 1, 0, 1, 1, 0, 3'd3, "R7");
    for (int i = 0; i < 3; i++) apply(1, 0, 0, 1, 0, 0, 3'd3, "R7");
    // R2: no common field
    for (int i = 0; i < 4; i++) apply(1, 1, 1, 1, 0, 0, 3'd0, "R2");
    for (int i = 0; i < 3; i++) apply(1, 0, 0, 0, 0, 0, 3'd0, "R2");
    // R9: second token while busy, 48 rows
    apply(1, 1, 0, 1, 0, 0, 3'd2, "R9");
    for (int i = 0; i < 5; i++)  apply(1, 0, 0, 1, 0, 0, 3'd2, "R9");
    apply(1, 1, 0, 1, 0, 0, 3'd2, "R9");
    for (int i = 0; i < 50; i++) apply(1, 0, 0, 1, 0, 0, 3'd2, "R9");
    // R10: shrink 120 -> 32 with tokens at stages 50 and 10
    apply(1, 1, 0, 1, 0, 0, 3'd7, "R10");
    for (int i = 0; i < 39; i++) apply(1, 0, 0, 1, 0, 0, 3'd7, "R10");
    apply(1, 1, 0, 1, 0, 0, 3'd7, "R10");
    for (int i = 0; i < 10; i++) apply(1, 0, 0, 1, 0, 0, 3'd7, "R10");
    for (int i = 0; i < 2; i++)  apply(0, 0, 0, 1, 0, 0, 3'd1, "R10");
    for (int i = 0; i < 24; i++) apply(1, 0, 0, 1, 0, 0, 3'd1, "R10");
    // R2: every length code, both directions
    for (int c = 1; c < 8; c++) begin
      apply(1, c[0], !c[0], c[0], 0, 0, 3'(c), "R2");
      for (int i = 0; i < len_of(3'(c)) + 1; i++)
        apply(1, 0, 0, c[0], 0, 0, 3'(c), "R2");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule